// File: doc/BRIEF.md
# Round-Robin FIFO Payload Interconnect

This block carries payload words from a set of producer-side queues to a set of consumer-side queues over one shared bus, all on a single clock. Each producer-side queue (an initiator) holds a link setting written by a control processor. The setting names the destination queue (a target) and how many words to send. Once a link is active and its initiator holds data, that initiator asks for the bus. A round-robin arbiter lets one initiator move one word per clock.

If the chosen target is full, the move is abandoned for that clock. The word stays at the head of its initiator and is offered again later. A link that has sent its whole word budget switches itself off and raises a sticky completion flag. The processor can read that flag and clear it. The initiator and target counts are parameters, so the bus can serve twenty or more queues.

Top module: `rr_payload_xbar`

## Requirements
- R1: Every queue is DEPTH words deep, first-in first-out, with a full flag (`in_full`) and an empty flag (`out_empty`). A push to a full initiator queue is ignored, and `out_data` shows the head word of each non-empty target.
- R2: A `cfg_we` pulse writes link `cfg_sel`. A target index below NT together with a non-zero count sets `link_active` on the next clock and clears that link's `link_done`.
- R3: A target index of NT or above leaves the link inactive and sets `cfg_err`. The next `cfg_we` with a valid index clears `cfg_err`.
- R4: At most one bit of `bus_gnt` is set. The grant goes to the first requesting initiator at or after the one following the previously granted initiator, in ascending index order with wraparound. A grant is always issued when any active link has data.
- R5: Each word that moves decrements the link's remaining count. When the count reaches zero, `link_active` falls and `link_done` rises in the same clock. `link_done` stays set until a `cfg_clr` pulse with `cfg_sel` selecting that link.
- R6: When the granted link's target is full, `bus_ok` is low. Nothing moves, and the word stays queued, so every word arrives in its original order once space frees up.
- R7: The arbiter moves past an initiator that was granted but blocked, so other links still deliver while one target is full.
- R8: Back-to-back requests from different initiators are served at one word per clock, with `bus_ok` high in every such cycle.
- R9: While `rst` is high, at the clock edge all links become inactive and all done flags, the error flag and all queues clear.
- R10: A link write with a count of zero leaves the link inactive and does not set `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| in_push | input | NI | Per-initiator write strobe |
| in_data | input | NI*DW | Per-initiator write word, initiator i at bits i*DW |
| in_full | output | NI | Per-initiator full flag |
| cfg_we | input | 1 | Write link setting |
| cfg_sel | input | IW | Link (initiator) index for a write or a clear |
| cfg_tgt | input | TW | Destination target index |
| cfg_cnt | input | CW | Word budget |
| cfg_clr | input | 1 | Clear the done flag of link `cfg_sel` |
| link_active | output | NI | Link enabled and budget not used up |
| link_done | output | NI | Sticky budget-complete flag |
| cfg_err | output | 1 | Last link write named an invalid target |
| bus_gnt | output | NI | One-hot grant for this cycle |
| bus_ok | output | 1 | Granted word moves this cycle |
| out_pop | input | NT | Per-target read strobe |
| out_data | output | NT*DW | Per-target head word, target t at bits t*DW |
| out_empty | output | NT | Per-target empty flag |

## Verification
A word pushed at clock edge k is in its initiator queue after edge k, is granted in the cycle that follows, and appears at the target head after edge k+1. The grant and `bus_ok` are combinational, so the bench reads them in the same cycle. Link status and `cfg_err` update one edge after `cfg_we`, and `link_done` updates at the edge that moves the last word. The bench drives and samples on falling edges, so each check reads state after a whole number of rising edges. Where arrival timing is not the point of a check, the bench polls the target empty flag for a bounded number of cycles before it compares data.

// File: rtl/rr_payload_xbar.sv
module rr_payload_xbar #(
  parameter int NI    = 4,
  parameter int NT    = 4,
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = (NI > 1) ? $clog2(NI) : 1,
  localparam int TW   = $clog2(NT) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NI-1:0]    in_push,
  input  logic [NI*DW-1:0] in_data,
  output logic [NI-1:0]    in_full,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_sel,
  input  logic [TW-1:0]    cfg_tgt,
  input  logic [CW-1:0]    cfg_cnt,
  input  logic             cfg_clr,
  output logic [NI-1:0]    link_active,
  output logic [NI-1:0]    link_done,
  output logic             cfg_err,
  output logic [NI-1:0]    bus_gnt,
  output logic             bus_ok,
  input  logic [NT-1:0]    out_pop,
  output logic [NT*DW-1:0] out_data,
  output logic [NT-1:0]    out_empty
);

  logic [DW-1:0] imem [NI][DEPTH];
  logic [AW-1:0] iwp [NI];
  logic [AW-1:0] irp [NI];
  logic [AW:0]   icnt [NI];
  logic [DW-1:0] tmem [NT][DEPTH];
  logic [AW-1:0] twp [NT];
  logic [AW-1:0] trp [NT];
  logic [AW:0]   tcnt [NT];
  logic [TW-1:0] ltgt [NI];
  logic [CW-1:0] lrem [NI];

  logic [NI-1:0] i_empty, req;
  logic [NT-1:0] t_full, t_push;
  logic [IW-1:0] rr_ptr, gidx;
  logic          gval;
  logic [TW-1:0] bus_tgt;
  logic [DW-1:0] bus_data;

  for (genvar i = 0; i < NI; i++) begin : g_ini
    logic ipush, ipop;
    assign i_empty[i] = (icnt[i] == '0);
    assign in_full[i] = (icnt[i] == (AW+1)'(DEPTH));
    assign req[i]     = link_active[i] & ~i_empty[i];
    assign ipush      = in_push[i] & ~in_full[i];
    assign ipop       = bus_ok & bus_gnt[i];

    always_ff @(posedge clk)
      if (ipush) imem[i][iwp[i]] <= in_data[i*DW +: DW];

    always_ff @(posedge clk) begin
      if (rst) begin
        iwp[i] <= '0; irp[i] <= '0; icnt[i] <= '0;
      end else begin
        if (ipush) iwp[i] <= iwp[i] + 1'b1;
        if (ipop)  irp[i] <= irp[i] + 1'b1;
        icnt[i] <= icnt[i] + (AW+1)'(ipush) - (AW+1)'(ipop);
      end
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_tgt
    logic tpop;
    assign out_empty[t] = (tcnt[t] == '0);
    assign t_full[t]    = (tcnt[t] == (AW+1)'(DEPTH));
    assign t_push[t]    = bus_ok & (bus_tgt == TW'(t));
    assign tpop         = out_pop[t] & ~out_empty[t];
    assign out_data[t*DW +: DW] = tmem[t][trp[t]];

    always_ff @(posedge clk)
      if (t_push[t]) tmem[t][twp[t]] <= bus_data;

    always_ff @(posedge clk) begin
      if (rst) begin
        twp[t] <= '0; trp[t] <= '0; tcnt[t] <= '0;
      end else begin
        if (t_push[t]) twp[t] <= twp[t] + 1'b1;
        if (tpop)      trp[t] <= trp[t] + 1'b1;
        tcnt[t] <= tcnt[t] + (AW+1)'(t_push[t]) - (AW+1)'(tpop);
      end
    end
  end

  always_comb begin
    int j;
    gval = 1'b0;
    gidx = rr_ptr;
    for (int k = NI - 1; k >= 0; k--) begin
      j = (int'(rr_ptr) + k) % NI;
      if (req[j]) begin
        gval = 1'b1;
        gidx = IW'(j);
      end
    end
  end

  assign bus_gnt  = gval ? (NI'(1) << gidx) : '0;
  assign bus_tgt  = ltgt[gidx];
  assign bus_data = imem[gidx][irp[gidx]];
  assign bus_ok   = gval & ~t_full[bus_tgt[TW-2:0]];

  always_ff @(posedge clk) begin
    if (rst) rr_ptr <= '0;
    else if (gval) rr_ptr <= (gidx == IW'(NI-1)) ? '0 : gidx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_active <= '0;
      link_done   <= '0;
      cfg_err     <= 1'b0;
      for (int i = 0; i < NI; i++) begin
        ltgt[i] <= '0;
        lrem[i] <= '0;
      end
    end else begin
      if (cfg_we) cfg_err <= (cfg_tgt >= TW'(NT));
      for (int i = 0; i < NI; i++) begin
        if (cfg_we && cfg_sel == IW'(i)) begin
          ltgt[i]        <= cfg_tgt;
          lrem[i]        <= cfg_cnt;
          link_done[i]   <= 1'b0;
          link_active[i] <= (cfg_tgt < TW'(NT)) && (cfg_cnt != '0);
        end else begin
          if (bus_ok && bus_gnt[i]) begin
            lrem[i] <= lrem[i] - 1'b1;
            if (lrem[i] == CW'(1)) begin
              link_active[i] <= 1'b0;
              link_done[i]   <= 1'b1;
            end
          end
          if (cfg_clr && cfg_sel == IW'(i)) link_done[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/rr_payload_xbar_chk.sv
module rr_payload_xbar_chk #(
  parameter int NI = 4,
  parameter int NT = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NI-1:0] bus_gnt,
  input logic [NI-1:0] req,
  input logic [NI-1:0] link_active,
  input logic [NI-1:0] link_done,
  input logic [NT-1:0] t_full,
  input logic [NT-1:0] out_pop,
  input logic [NT-1:0] out_empty
);

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_gnt));

  assert_grant_on_request_R4: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> (|bus_gnt));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (link_active == '0 && link_done == '0 && &out_empty));

  for (genvar i = 0; i < NI; i++) begin : g_link
    assert_done_ends_link_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(link_done[i]) |-> $fell(link_active[i]));
  end

  for (genvar t = 0; t < NT; t++) begin : g_full
    assert_full_holds_R6: assert property (@(posedge clk) disable iff (rst)
      (t_full[t] && !out_pop[t]) |=> t_full[t]);
  end

endmodule

bind rr_payload_xbar rr_payload_xbar_chk #(.NI(NI), .NT(NT)) chk_i (
  .clk(clk), .rst(rst), .bus_gnt(bus_gnt), .req(req),
  .link_active(link_active), .link_done(link_done),
  .t_full(t_full), .out_pop(out_pop), .out_empty(out_empty)
);

// File: tb/rr_payload_xbar_tb_top.sv
module rr_payload_xbar_tb_top;
  localparam int NI = 4, NT = 4, DW = 32, DEPTH = 16, CW = 16;
  localparam int IW = 2, TW = 3;
  localparam int NV = 6;
  // initiator, target, count, words pushed, words expected at target
  localparam int VEC [NV][5] = '{
    '{0, 0, 3, 3, 3}, '{1, 2, 2, 5, 2}, '{2, 3, 4, 4, 4},
    '{3, 1, 1, 1, 1}, '{1, 3, 16, 16, 16}, '{0, 2, 6, 4, 4}};

  logic clk = 0, rst = 1;
  logic [NI-1:0] in_push = '0;
  logic [NI*DW-1:0] in_data = '0;
  logic [NI-1:0] in_full, link_active, link_done, bus_gnt;
  logic cfg_we = 0, cfg_clr = 0, cfg_err, bus_ok;
  logic [IW-1:0] cfg_sel = '0;
  logic [TW-1:0] cfg_tgt = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic [NT-1:0] out_pop = '0, out_empty;
  logic [NT*DW-1:0] out_data;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  rr_payload_xbar #(.NI(NI), .NT(NT), .DW(DW), .DEPTH(DEPTH), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .in_push(in_push), .in_data(in_data), .in_full(in_full),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_tgt(cfg_tgt), .cfg_cnt(cfg_cnt),
    .cfg_clr(cfg_clr), .link_active(link_active), .link_done(link_done),
    .cfg_err(cfg_err), .bus_gnt(bus_gnt), .bus_ok(bus_ok), .out_pop(out_pop),
    .out_data(out_data), .out_empty(out_empty));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; in_push = '0; out_pop = '0; cfg_we = 0; cfg_clr = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic cfg_write(int sel, int tgt, int cnt);
    @(negedge clk); cfg_we = 1; cfg_sel = IW'(sel); cfg_tgt = TW'(tgt); cfg_cnt = CW'(cnt);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic push(int i, logic [DW-1:0] d);
    @(negedge clk); in_push[i] = 1; in_data[i*DW +: DW] = d;
    @(negedge clk); in_push[i] = 0;
  endtask

  task automatic pop_expect(string tag, int t, logic [DW-1:0] exp);
    int guard = 0;
    while (out_empty[t] && guard < 60) begin @(negedge clk); guard++; end
    check(tag, out_data[t*DW +: DW], exp);
    out_pop[t] = 1;
    @(negedge clk);
    out_pop[t] = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9 reset state
    do_reset();
    check("R9 active", link_active, 0);
    check("R9 done", link_done, 0);
    check("R9 err", cfg_err, 0);
    check("R9 empty", out_empty, 4'hF);
    check("R9 full", in_full, 0);
    check("R9 gnt", bus_gnt, 0);

    // Table: R2 and R5 across links and targets
    for (int v = 0; v < NV; v++) begin
      do_reset();
      cfg_write(VEC[v][0], VEC[v][1], VEC[v][2]);
      check("R2 link on", link_active[VEC[v][0]], 1);
      for (int k = 0; k < VEC[v][3]; k++) push(VEC[v][0], {8'(v), 24'(k)});
      repeat (20) @(negedge clk);
      check("R5 done", link_done[VEC[v][0]], VEC[v][4] == VEC[v][2]);
      check("R5 active", link_active[VEC[v][0]], VEC[v][4] != VEC[v][2]);
      for (int k = 0; k < VEC[v][4]; k++) pop_expect("R5 data", VEC[v][1], {8'(v), 24'(k)});
      check("R5 no extra", out_empty[VEC[v][1]], 1);
    end

    // R3 bad target, then valid write clears error
    do_reset();
    cfg_write(1, 5, 3);
    check("R3 err", cfg_err, 1);
    check("R3 inactive", link_active[1], 0);
    push(1, 32'hBAD0);
    repeat (5) @(negedge clk);
    check("R3 nothing moved", out_empty, 4'hF);
    cfg_write(1, 2, 1);
    check("R3 err clear", cfg_err, 0);
    pop_expect("R3 data after fix", 2, 32'hBAD0);

    // R10 zero count
    do_reset();
    cfg_write(2, 0, 0);
    check("R10 inactive", link_active[2], 0);
    check("R10 no err", cfg_err, 0);
    push(2, 32'h2222);
    repeat (5) @(negedge clk);
    check("R10 nothing moved", out_empty, 4'hF);

    // R4 / R8 round robin at full rate
    do_reset();
    for (int i = 0; i < NI; i++) cfg_write(i, 0, 2);
    @(negedge clk); in_push = 4'hF;
    for (int i = 0; i < NI; i++) in_data[i*DW +: DW] = 32'h100 + i;
    @(negedge clk);
    for (int i = 0; i < NI; i++) in_data[i*DW +: DW] = 32'h200 + i;
    check("R4 gnt c0", bus_gnt, 4'b0001);
    check("R8 ok c0", bus_ok, 1);
    @(negedge clk); in_push = '0;
    for (int c = 1; c < 8; c++) begin
      check("R4 gnt rotate", bus_gnt, 4'b0001 << (c % 4));
      check("R8 ok each", bus_ok, 1);
      @(negedge clk);
    end
    check("R4 all done", link_done, 4'hF);
    for (int c = 0; c < 8; c++) pop_expect("R4 order", 0, (c < 4 ? 32'h100 : 32'h200) + (c % 4));

    // R6 / R7 full target keeps words, other link still served
    do_reset();
    cfg_write(0, 1, 20);
    for (int k = 0; k < 16; k++) push(0, 32'hA000 + k);
    repeat (5) @(negedge clk);
    for (int k = 16; k < 20; k++) push(0, 32'hA000 + k);
    cfg_write(1, 2, 2);
    push(1, 32'hB000); push(1, 32'hB001);
    repeat (6) @(negedge clk);
    check("R6 blocked gnt", bus_gnt, 4'b0001);
    check("R6 aborted", bus_ok, 0);
    check("R6 still active", link_active[0], 1);
    check("R7 other done", link_done[1], 1);
    pop_expect("R7 other data", 2, 32'hB000);
    pop_expect("R7 other data", 2, 32'hB001);
    for (int k = 0; k < 20; k++) pop_expect("R6 no loss", 1, 32'hA000 + k);
    check("R5 done after drain", link_done[0], 1);
    @(negedge clk); cfg_clr = 1; cfg_sel = 0;
    @(negedge clk); cfg_clr = 0;
    check("R5 clear", link_done[0], 0);
    check("R5 clear other kept", link_done[1], 1);

    // R1 initiator full, extra pushes ignored
    do_reset();
    for (int k = 0; k < 18; k++) push(3, 32'hC000 + k);
    check("R1 full", in_full[3], 1);
    cfg_write(3, 0, 18);
    repeat (25) @(negedge clk);
    check("R1 not full after drain", in_full[3], 0);
    for (int k = 0; k < 16; k++) pop_expect("R1 data", 0, 32'hC000 + k);
    check("R1 dropped pushes", out_empty[0], 1);
    check("R1 budget left", link_active[3], 1);

    finish_run();
  end
endmodule